// File: doc/BRIEF.md
# Type-C Port Role and Status Indicator

This block sits beside a Type-C configuration-channel classifier and turns its digitized results into the port's pin-level indications. It decodes two three-level strap inputs, each presented as a pre-decoded 2-bit code. The role strap selects host (downstream-facing), device (upstream-facing) or dual-role operation. The address strap selects either register-controlled operation, with one of two bus addresses, or standalone operation. Each open-drain output is modelled as a drive-low enable.

After reset or after leaving hibernation, the block waits a fixed latch delay and then samples the address strap once. In register mode the role strap is captured at that same moment, and from then on only a register write can change the role. In standalone mode the role strap is followed continuously. Three shared pins carry either bus and interrupt duties (register mode) or current-advertisement and audio-accessory indications (standalone mode). The address pin turns into a connection-detect output once the delay has passed.

The serial bus engine is replaced by a plain register write and read port. Reading the status register acknowledges a pending interrupt.

Top module: `typec_role_ind`

## Requirements
- R1: Role codes: strap code 2'b10 selects host (role_o = 2'd2), 2'b01 or 2'b11 selects dual-role (role_o = 2'd1), and 2'b00 selects device (role_o = 2'd0). In standalone mode role_o follows the strap one clock after it changes.
- R2: LATCH_CYC clocks after reset or after hibernation ends, the address strap is sampled once. Code 2'b10 gives register mode with bus_addr_o = 0x7A. Code 2'b00 gives register mode with bus_addr_o = 0x3A. Code 2'b01 or 2'b11 gives standalone mode with bus_addr_o = 0. The result then stays fixed.
- R3: In register mode the role is taken from the strap at the latch instant, and later strap changes are ignored. A write to address 2 sets the role from wr_data_i[1:0]. A write with value 3 leaves the role unchanged.
- R4: In standalone mode, pins 1 and 2 show the classifier's advertisement code adv_i. Code 2 (high current) pulls pin 2 low. Code 1 (medium current) pulls pin 1 low. Codes 0 and 3 (default current) leave both pins released. In register mode neither pin is pulled.
- R5: Pin 3 is pulled low while an audio accessory is seen in standalone mode. In register mode it is pulled low while an interrupt is pending.
- R6: In register mode, an interrupt becomes pending one clock after any change of att_i or adv_i. It stays pending until a read of address 3. If a new event arrives in the same clock as the read, the interrupt stays pending.
- R7: The ID pin is pulled low only while the role is host and a valid device is seen (dev_i), one clock after the inputs.
- R8: The connection-detect pin is enabled as an output after the latch delay in standalone mode, or in register mode once bit 0 of address 9 has been cleared. That bit resets to 1. While enabled, the pin is pulled low when nothing is attached.
- R9: The status register at address 3 reads {3'b0, dev, adv[1:0], audio, attached}. Bit 0 is 0 whenever no attachment is seen.
- R10: While hib_i is high, all registers return to their reset values and every output is released. The latch delay restarts when hib_i falls.
- R11: Until the latch delay has passed, every pull output and cdet_oe_o stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hib_i | input | 1 | Hibernation request, clears all state |
| role_lvl_i | input | 2 | Role strap code (00 low, 01 mid, 10 high, 11 floating) |
| addr_lvl_i | input | 2 | Address strap code, same coding |
| att_i | input | 1 | Classifier: external attachment present |
| dev_i | input | 1 | Classifier: valid device on either CC line |
| adv_i | input | 2 | Classifier: advertised current (0 default, 1 medium, 2 high) |
| aud_i | input | 1 | Classifier: audio accessory present |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| role_o | output | 2 | Effective role |
| reg_mode_o | output | 1 | Register mode selected |
| bus_addr_o | output | 7 | Selected bus address, 0 in standalone mode |
| id_pull_o | output | 1 | Drive ID pin low |
| p1_pull_o | output | 1 | Drive shared pin 1 low |
| p2_pull_o | output | 1 | Drive shared pin 2 low |
| p3_pull_o | output | 1 | Drive shared pin 3 low (interrupt or audio) |
| cdet_oe_o | output | 1 | Address pin acts as connection-detect output |
| cdet_pull_o | output | 1 | Drive connection-detect pin low |

## Verification
Assertions check on every cycle that:
- a register-mode role never moves without a role write;
- the latched address stays fixed;
- a status read with no new event drops the interrupt;
- the ID pull never appears without a device having been seen;
- the bus pins stay released in register mode;
- hibernation releases the outputs.

Only the bench scenarios can show the decode tables, the order of latching against later strap changes, the priority of an event over a read in the same clock, and the full restart of the latch delay after hibernation.

// File: rtl/tcri_pkg.sv
package tcri_pkg;
  typedef enum logic [1:0] {
    ROLE_DEV  = 2'd0,
    ROLE_DRP  = 2'd1,
    ROLE_HOST = 2'd2
  } role_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  localparam logic [3:0] RA_ROLE   = 4'h2;
  localparam logic [3:0] RA_STAT   = 4'h3;
  localparam logic [3:0] RA_PINCFG = 4'h9;

  localparam logic [6:0] BUS_ADDR_HI = 7'h7A;
  localparam logic [6:0] BUS_ADDR_LO = 7'h3A;

  function automatic role_e lvl2role(input logic [1:0] lvl);
    case (lvl)
      LVL_HIGH: lvl2role = ROLE_HOST;
      LVL_LOW:  lvl2role = ROLE_DEV;
      default:  lvl2role = ROLE_DRP;
    endcase
  endfunction
endpackage

// File: rtl/tcri_strap.sv
module tcri_strap #(
  parameter int LATCH_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hib_i,
  input  logic [1:0] addr_lvl_i,
  output logic       ready_o,
  output logic       latch_o,
  output logic       reg_mode_o,
  output logic [6:0] bus_addr_o
);
  import tcri_pkg::*;

  localparam int CW = $clog2(LATCH_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LATCH_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ready_q, ready_d;
  logic          mode_q, mode_d;
  logic [6:0]    addr_q, addr_d;

  assign latch_o = !ready_q && !hib_i && (cnt_q == LAST);

  always_comb begin
    cnt_d   = cnt_q;
    ready_d = ready_q;
    mode_d  = mode_q;
    addr_d  = addr_q;
    if (hib_i) begin
      cnt_d   = '0;
      ready_d = 1'b0;
      mode_d  = 1'b0;
      addr_d  = '0;
    end else if (latch_o) begin
      ready_d = 1'b1;
      case (addr_lvl_i)
        LVL_HIGH: begin mode_d = 1'b1; addr_d = BUS_ADDR_HI; end
        LVL_LOW:  begin mode_d = 1'b1; addr_d = BUS_ADDR_LO; end
        default:  begin mode_d = 1'b0; addr_d = '0;          end
      endcase
    end else if (!ready_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      mode_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
      mode_q  <= mode_d;
      addr_q  <= addr_d;
    end
  end

  assign ready_o    = ready_q;
  assign reg_mode_o = mode_q;
  assign bus_addr_o = addr_q;

  AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !hib_i) |=> ($stable(addr_q) && $stable(mode_q))); // R2
endmodule

// File: rtl/tcri_regs.sv
module tcri_regs (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hib_i,
  input  logic                 ready_i,
  input  logic                 latch_i,
  input  logic                 reg_mode_i,
  input  logic [1:0]           role_lvl_i,
  input  logic                 att_i,
  input  logic                 dev_i,
  input  logic [1:0]           adv_i,
  input  logic                 aud_i,
  input  logic                 wr_en_i,
  input  logic [3:0]           wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic                 rd_en_i,
  input  logic [3:0]           rd_addr_i,
  output logic [7:0]           rd_data_o,
  output tcri_pkg::role_e      role_o,
  output logic                 pend_o,
  output logic                 pincfg_o,
  output logic                 att_o,
  output logic                 dev_o,
  output logic [1:0]           adv_o,
  output logic                 aud_o
);
  import tcri_pkg::*;

  role_e      role_q, role_d;
  logic       pend_q, pend_d;
  logic       pcfg_q, pcfg_d;
  logic       att_q, dev_q, aud_q;
  logic [1:0] adv_q;
  logic       evt, wr_ok, rd_stat;

  assign wr_ok   = wr_en_i && ready_i && reg_mode_i;
  assign rd_stat = rd_en_i && (rd_addr_i == RA_STAT);
  assign evt     = ready_i && reg_mode_i && ((att_i != att_q) || (adv_i != adv_q));

  always_comb begin
    role_d = role_q;
    pcfg_d = pcfg_q;
    pend_d = pend_q;
    if (hib_i) begin
      role_d = ROLE_DEV;
      pcfg_d = 1'b1;
      pend_d = 1'b0;
    end else begin
      if (latch_i || (ready_i && !reg_mode_i))
        role_d = lvl2role(role_lvl_i);
      else if (wr_ok && (wr_addr_i == RA_ROLE) && (wr_data_i[1:0] != 2'b11))
        role_d = role_e'(wr_data_i[1:0]);
      if (wr_ok && (wr_addr_i == RA_PINCFG))
        pcfg_d = wr_data_i[0];
      if (evt)
        pend_d = 1'b1;
      else if (rd_stat)
        pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_q <= ROLE_DEV;
      pcfg_q <= 1'b1;
      pend_q <= 1'b0;
      att_q  <= 1'b0;
      dev_q  <= 1'b0;
      adv_q  <= 2'b00;
      aud_q  <= 1'b0;
    end else begin
      role_q <= role_d;
      pcfg_q <= pcfg_d;
      pend_q <= pend_d;
      att_q  <= att_i && !hib_i;
      dev_q  <= dev_i && !hib_i;
      adv_q  <= hib_i ? 2'b00 : adv_i;
      aud_q  <= aud_i && !hib_i;
    end
  end

  always_comb begin
    case (rd_addr_i)
      RA_ROLE:   rd_data_o = {6'b0, role_q};
      RA_STAT:   rd_data_o = {3'b0, dev_q, adv_q, aud_q, att_q};
      RA_PINCFG: rd_data_o = {7'b0, pcfg_q};
      default:   rd_data_o = 8'h00;
    endcase
  end

  assign role_o   = role_q;
  assign pend_o   = pend_q;
  assign pincfg_o = pcfg_q;
  assign att_o    = att_q;
  assign dev_o    = dev_q;
  assign adv_o    = adv_q;
  assign aud_o    = aud_q;

  AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && reg_mode_i && !hib_i && !(wr_en_i && wr_addr_i == RA_ROLE))
      |=> $stable(role_q)); // R3
  AST_PEND_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && rd_stat && !hib_i && att_i == att_q && adv_i == adv_q)
      |=> !pend_q); // R6
endmodule

// File: rtl/tcri_pins.sv
module tcri_pins (
  input  logic            ready_i,
  input  logic            reg_mode_i,
  input  tcri_pkg::role_e role_i,
  input  logic            att_i,
  input  logic            dev_i,
  input  logic [1:0]      adv_i,
  input  logic            aud_i,
  input  logic            pend_i,
  input  logic            pincfg_i,
  output logic            id_pull_o,
  output logic            p1_pull_o,
  output logic            p2_pull_o,
  output logic            p3_pull_o,
  output logic            cdet_oe_o,
  output logic            cdet_pull_o
);
  import tcri_pkg::*;

  logic alone;
  assign alone = ready_i && !reg_mode_i;

  always_comb begin
    p1_pull_o = 1'b0;
    p2_pull_o = 1'b0;
    if (alone) begin
      case (adv_i)
        2'd2:    p2_pull_o = 1'b1;
        2'd1:    p1_pull_o = 1'b1;
        default: ;
      endcase
    end
  end

  assign p3_pull_o   = ready_i && (reg_mode_i ? pend_i : aud_i);
  assign id_pull_o   = ready_i && (role_i == ROLE_HOST) && dev_i;
  assign cdet_oe_o   = ready_i && (!reg_mode_i || !pincfg_i);
  assign cdet_pull_o = cdet_oe_o && !att_i;
endmodule

// File: rtl/typec_role_ind.sv
module typec_role_ind #(
  parameter int LATCH_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hib_i,
  input  logic [1:0] role_lvl_i,
  input  logic [1:0] addr_lvl_i,
  input  logic       att_i,
  input  logic       dev_i,
  input  logic [1:0] adv_i,
  input  logic       aud_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic [1:0] role_o,
  output logic       reg_mode_o,
  output logic [6:0] bus_addr_o,
  output logic       id_pull_o,
  output logic       p1_pull_o,
  output logic       p2_pull_o,
  output logic       p3_pull_o,
  output logic       cdet_oe_o,
  output logic       cdet_pull_o
);
  import tcri_pkg::*;

  logic       ready, latch, reg_mode, pend, pincfg;
  logic       att_q, dev_q, aud_q;
  logic [1:0] adv_q;
  role_e      role;

  tcri_strap #(.LATCH_CYC(LATCH_CYC)) u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .hib_i      (hib_i),
    .addr_lvl_i (addr_lvl_i),
    .ready_o    (ready),
    .latch_o    (latch),
    .reg_mode_o (reg_mode),
    .bus_addr_o (bus_addr_o)
  );

  tcri_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .hib_i      (hib_i),
    .ready_i    (ready),
    .latch_i    (latch),
    .reg_mode_i (reg_mode),
    .role_lvl_i (role_lvl_i),
    .att_i      (att_i),
    .dev_i      (dev_i),
    .adv_i      (adv_i),
    .aud_i      (aud_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .role_o     (role),
    .pend_o     (pend),
    .pincfg_o   (pincfg),
    .att_o      (att_q),
    .dev_o      (dev_q),
    .adv_o      (adv_q),
    .aud_o      (aud_q)
  );

  tcri_pins u_pins (
    .ready_i     (ready),
    .reg_mode_i  (reg_mode),
    .role_i      (role),
    .att_i       (att_q),
    .dev_i       (dev_q),
    .adv_i       (adv_q),
    .aud_i       (aud_q),
    .pend_i      (pend),
    .pincfg_i    (pincfg),
    .id_pull_o   (id_pull_o),
    .p1_pull_o   (p1_pull_o),
    .p2_pull_o   (p2_pull_o),
    .p3_pull_o   (p3_pull_o),
    .cdet_oe_o   (cdet_oe_o),
    .cdet_pull_o (cdet_pull_o)
  );

  assign role_o     = role;
  assign reg_mode_o = reg_mode;

  AST_ID_NEEDS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    id_pull_o |-> $past(dev_i)); // R7
  AST_BUS_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_mode_o |-> (!p1_pull_o && !p2_pull_o)); // R4
  AST_HIB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    hib_i |=> (!cdet_oe_o && !id_pull_o && !p3_pull_o && !reg_mode_o)); // R10
endmodule

// File: tb/sim_typec_role_ind.sv
module sim_typec_role_ind;
  localparam int LATCH_CYC = 8;

  logic       clk = 1'b0;
  logic       rst_n, hib_i;
  logic [1:0] role_lvl_i, addr_lvl_i, adv_i;
  logic       att_i, dev_i, aud_i;
  logic       wr_en_i, rd_en_i;
  logic [3:0] wr_addr_i, rd_addr_i;
  logic [7:0] wr_data_i, rd_data_o;
  logic [1:0] role_o;
  logic       reg_mode_o;
  logic [6:0] bus_addr_o;
  logic       id_pull_o, p1_pull_o, p2_pull_o, p3_pull_o, cdet_oe_o, cdet_pull_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  typec_role_ind #(.LATCH_CYC(LATCH_CYC)) u0 (.*);

  // {role_lvl, att, dev, adv, aud, exp_role, exp_id, exp_p1, exp_p2, exp_p3, exp_cdet_pull}
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    14'b10_1_1_00_0_10_1_0_0_0_0,
    14'b10_0_0_10_0_10_0_0_1_0_1,
    14'b00_1_1_01_0_00_0_1_0_0_0,
    14'b01_1_1_10_1_01_0_0_1_1_0,
    14'b11_0_0_11_1_01_0_0_0_1_1,
    14'b10_1_0_01_1_10_0_1_0_1_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] addr, input logic [1:0] role);
    rst_n = 1'b0; hib_i = 1'b0;
    addr_lvl_i = addr; role_lvl_i = role;
    att_i = 0; dev_i = 0; adv_i = 0; aud_i = 0;
    wr_en_i = 0; rd_en_i = 0; wr_addr_i = 0; rd_addr_i = 0; wr_data_i = 0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  initial begin
    // Standalone strap
    do_reset(2'b01, 2'b10);
    step(1);
    chk("R11 cdet_oe before latch", cdet_oe_o, 0);
    chk("R11 pulls before latch", {id_pull_o, p1_pull_o, p2_pull_o, p3_pull_o, cdet_pull_o}, 0);
    step(LATCH_CYC + 1);
    chk("R2 standalone mode", {reg_mode_o, bus_addr_o}, 0);
    chk("R8 cdet output in standalone", cdet_oe_o, 1);
    for (int i = 0; i < NV; i++) begin
      {role_lvl_i, att_i, dev_i, adv_i, aud_i} = VEC[i][13:7];
      step(1);
      chk("R1 role decode", role_o, VEC[i][6:5]);
      chk("R7 id pull", id_pull_o, VEC[i][4]);
      chk("R4 current code", {p1_pull_o, p2_pull_o}, VEC[i][3:2]);
      chk("R5 audio pin", p3_pull_o, VEC[i][1]);
      chk("R8 cdet level", cdet_pull_o, VEC[i][0]);
    end

    // Register mode, high address
    do_reset(2'b10, 2'b00);
    step(LATCH_CYC + 2);
    chk("R2 reg mode high addr", {reg_mode_o, bus_addr_o}, {1'b1, 7'h7A});
    chk("R3 role latched", role_o, 0);
    chk("R8 cdet input by default", cdet_oe_o, 0);
    role_lvl_i = 2'b10;
    step(3);
    chk("R3 strap ignored after latch", role_o, 0);
    wr(4'h2, 8'h02);
    chk("R3 role write", role_o, 2);
    wr(4'h2, 8'h03);
    chk("R3 role write of 3 ignored", role_o, 2);
    dev_i = 1'b1;
    step(1);
    chk("R7 id pull in host", id_pull_o, 1);
    att_i = 1'b1; adv_i = 2'd2;
    step(1);
    chk("R6 interrupt on attach", p3_pull_o, 1);
    chk("R4 bus pins quiet", {p1_pull_o, p2_pull_o}, 0);
    rd_en_i = 1'b1; rd_addr_i = 4'h3;
    #1;
    chk("R9 status layout", rd_data_o, 8'h19);
    step(1);
    rd_en_i = 1'b0;
    chk("R6 read acknowledges", p3_pull_o, 0);
    adv_i = 2'd1; rd_en_i = 1'b1;
    step(1);
    rd_en_i = 1'b0;
    chk("R6 event beats read", p3_pull_o, 1);
    att_i = 1'b0; dev_i = 1'b0;
    step(1);
    rd_en_i = 1'b1;
    #1;
    chk("R9 attach bit cleared", rd_data_o[0], 0);
    step(1);
    rd_en_i = 1'b0;
    chk("R6 cleared by read", p3_pull_o, 0);
    wr(4'h9, 8'h00);
    chk("R8 cdet after cfg clear", {cdet_oe_o, cdet_pull_o}, 2'b11);

    // Hibernation
    dev_i = 1'b1;
    hib_i = 1'b1; addr_lvl_i = 2'b00;
    step(1);
    chk("R10 hib releases", {cdet_oe_o, id_pull_o, p3_pull_o, reg_mode_o}, 0);
    chk("R10 role cleared", role_o, 0);
    hib_i = 1'b0;
    step(LATCH_CYC - 2);
    chk("R10 latch delay restarts", {reg_mode_o, cdet_oe_o}, 0);
    step(3);
    chk("R10 relatch low addr", {reg_mode_o, bus_addr_o}, {1'b1, 7'h3A});
    chk("R10 pincfg back to 1", cdet_oe_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule